// File: doc/BRIEF.md
# Internal-Clock Conversion and Calibration Timer

This block sequences the two operations of a serial converter front end that run on a local free-running clock. The first is a conversion timed by that clock. The second is a calibration, which can be requested for either clock source. The block drives a strobe/busy line whose polarity depends on the clock source. It times a parameterised conversion length or the much longer calibration length. When a conversion ends, the block captures the result word into a holding shift register. The host then reads that word out on falling edges of the serial clock, at any time it chooses.

The successive-approximation decisions and the calibration arithmetic are not modelled. The result word arrives on `sample_in` and is captured on the cycle the conversion finishes. A calibration only consumes time. The serial clock is expected to be already synchronous to `clk`. The block detects its falling edges with one register.

A command is accepted when `cmd_valid` is high, `shdn_n` is high, and the command is either a calibration or an internal-clock conversion. An accepted command always starts a fresh operation, even if one is already running. `abort` represents a valid new start condition. `abort` or a low `shdn_n` ends the current operation early.

Top module: `intclk_conv_timer`

## Requirements
- R1: After reset, busy=0, done=0, strobe=1, strobe_oe=1 and dout=0, and internal clock mode is selected.
- R2: An accepted internal-clock conversion holds busy high for exactly CONV_CYCLES clock cycles, starting the cycle after the command. Strobe is 0 during those cycles and returns to 1 as busy falls.
- R3: On the cycle a conversion completes, sample_in is captured and done rises. The result MSB (bit W-1) is on dout in the same cycle that strobe rises.
- R4: While done=1, each falling edge of sclk seen with cs_n=0 presents the next lower bit on dout. The (W-1)th such edge presents the LSB and clears done. Later edges leave dout unchanged, and falling edges seen with cs_n=1 shift nothing.
- R5: In internal clock mode strobe_oe is 1 whatever cs_n is. In external clock mode strobe_oe equals the inverse of cs_n.
- R6: An internal-clock calibration (cmd_cal=1, cmd_int_clk=1) holds busy high for exactly CAL_CYCLES cycles with strobe at 0. Strobe then returns to 1, and done stays 0.
- R7: An external-clock calibration (cmd_cal=1, cmd_int_clk=0) selects external mode. Strobe is 1 for the CAL_CYCLES busy cycles and 0 afterwards.
- R8: A pulse on abort, or shdn_n low, during an operation drops busy and done on the next cycle. dout is left unchanged, and strobe goes to the idle level of the current mode.
- R9: A command accepted while an operation is running restarts timing, so busy then stays high for the full length of the new operation.
- R10: A conversion command with external clock selected (cmd_cal=0, cmd_int_clk=0) is ignored. It changes neither busy nor the clock mode.
- R11: Commands presented while shdn_n is low are ignored.
- R12: Reset returns the block to internal clock mode, so strobe idles at 1 again after an external calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shdn_n | input | 1 | Active-low shutdown, halts any operation |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_cal | input | 1 | 1 = calibration, 0 = conversion |
| cmd_int_clk | input | 1 | 1 = internal clock source, 0 = external |
| abort | input | 1 | Valid new start condition seen, ends the current operation |
| sample_in | input | W | Placeholder conversion result |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| strobe | output | 1 | Busy/strobe level, polarity set by the clock mode |
| strobe_oe | output | 1 | Output enable for the strobe pad |
| dout | output | 1 | Serial result bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result waiting to be read |

## Verification
On every cycle, the assertions tie each accepted command to busy rising and done clearing. They check that an early stop lands in idle and that a conversion end raises done. They also check that dout never moves without a load or an enabled falling edge, and that a calibration never sets done. Only the bench scenarios show the exact busy lengths, the strobe polarity per clock source, and the bit order across a full readback. The same holds for the output-enable behaviour with chip select high and for reset restoring internal mode.

// File: rtl/itc_pkg.sv
package itc_pkg;

  // Number of clock cycles an accepted operation keeps the block busy.
  function automatic int op_length(input logic is_cal, input int conv_len, input int cal_len);
    return is_cal ? cal_len : conv_len;
  endfunction

  // Strobe level: internal mode signals busy as low, external mode as high.
  function automatic logic strobe_level(input logic busy, input logic int_clk);
    return int_clk ? ~busy : busy;
  endfunction

endpackage

// File: rtl/itc_op_counter.sv
module itc_op_counter #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [CW-1:0] dur,
  output logic          running,
  output logic          fin
);
  logic [CW-1:0] cnt;

  assign fin = running && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= dur - 1'b1;
      running <= 1'b1;
    end else if (clear) begin
      running <= 1'b0;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/itc_rd_shifter.sv
module itc_rd_shifter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         dout,
  output logic         last
);
  localparam int NW = $clog2(W);

  logic [W-1:0]  sr;
  logic [NW-1:0] n;

  assign dout = sr[W-1];
  assign last = shift && (n == NW'(W-2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
      n  <= '0;
    end else if (load) begin
      sr <= din;
      n  <= '0;
    end else if (shift) begin
      sr <= {sr[W-2:0], 1'b0};
      n  <= n + 1'b1;
    end
  end
endmodule

// File: rtl/intclk_conv_timer.sv
module intclk_conv_timer #(
  parameter int W           = 14,
  parameter int CONV_CYCLES = 24,
  parameter int CAL_CYCLES  = 80000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shdn_n,
  input  logic         cmd_valid,
  input  logic         cmd_cal,
  input  logic         cmd_int_clk,
  input  logic         abort,
  input  logic [W-1:0] sample_in,
  input  logic         sclk,
  input  logic         cs_n,
  output logic         strobe,
  output logic         strobe_oe,
  output logic         dout,
  output logic         busy,
  output logic         done
);
  import itc_pkg::*;

  localparam int LONGEST = (CAL_CYCLES > CONV_CYCLES) ? CAL_CYCLES : CONV_CYCLES;
  localparam int CW      = $clog2(LONGEST + 1);

  // Named internal events (observed by the bound checker)
  logic start_ok, kill, fin, complete;
  logic rd_load, rd_shift, rd_last;
  logic sclk_q, sclk_fall;
  logic op_cal, mode_int, pending, running;
  logic [CW-1:0] dur;

  assign start_ok  = cmd_valid & shdn_n & (cmd_cal | cmd_int_clk);
  assign kill      = ~shdn_n | abort;
  assign complete  = fin & ~kill & ~start_ok;
  assign rd_load   = complete & ~op_cal;
  assign sclk_fall = sclk_q & ~sclk;
  assign rd_shift  = sclk_fall & ~cs_n & pending;
  assign dur       = CW'(op_length(cmd_cal, CONV_CYCLES, CAL_CYCLES));

  itc_op_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_ok),
    .clear   (kill & ~start_ok),
    .dur     (dur),
    .running (running),
    .fin     (fin)
  );

  itc_rd_shifter #(.W(W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_load),
    .din   (sample_in),
    .shift (rd_shift),
    .dout  (dout),
    .last  (rd_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      op_cal   <= 1'b0;
      mode_int <= 1'b1;
      pending  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (start_ok) begin
        op_cal   <= cmd_cal;
        mode_int <= cmd_int_clk;
      end
      if (start_ok || kill) pending <= 1'b0;
      else if (rd_load)     pending <= 1'b1;
      else if (rd_last)     pending <= 1'b0;
    end
  end

  assign busy      = running;
  assign done      = pending;
  assign strobe    = strobe_level(running, mode_int);
  assign strobe_oe = mode_int | ~cs_n;
endmodule

// File: rtl/itc_checker.sv
module itc_checker (
  input logic clk,
  input logic rst_n,
  input logic shdn_n,
  input logic busy,
  input logic done,
  input logic dout,
  input logic start_ok,
  input logic kill,
  input logic fin,
  input logic op_cal,
  input logic rd_shift,
  input logic rd_load
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy && !done);                                   // R9
  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kill && !start_ok |=> !busy && !done);                         // R8
  AST_FIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !op_cal && !kill && !start_ok |=> done && !busy);       // R3
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_shift && !rd_load |=> $stable(dout));                      // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                               // R2
  AST_CAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_cal |-> !done);                                     // R6
  AST_SHDN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> !busy);                                            // R11
endmodule

bind intclk_conv_timer itc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shdn_n   (shdn_n),
  .busy     (busy),
  .done     (done),
  .dout     (dout),
  .start_ok (start_ok),
  .kill     (kill),
  .fin      (fin),
  .op_cal   (op_cal),
  .rd_shift (rd_shift),
  .rd_load  (rd_load)
);

// File: tb/sim_intclk_conv_timer.sv
`timescale 1ns/1ps
module sim_intclk_conv_timer;
  localparam int W    = 14;
  localparam int CONV = 24;
  localparam int CAL  = 200;

  logic clk = 0, rst_n = 0, shdn_n = 1, cmd_valid = 0, cmd_cal = 0, cmd_int_clk = 1;
  logic abort = 0, sclk = 0, cs_n = 0;
  logic [W-1:0] sample_in = '0;
  logic strobe, strobe_oe, dout, busy, done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  intclk_conv_timer #(.W(W), .CONV_CYCLES(CONV), .CAL_CYCLES(CAL)) u0 (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cmd_valid(cmd_valid), .cmd_cal(cmd_cal),
    .cmd_int_clk(cmd_int_clk), .abort(abort), .sample_in(sample_in), .sclk(sclk),
    .cs_n(cs_n), .strobe(strobe), .strobe_oe(strobe_oe), .dout(dout), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic cal, input logic intc);
    @(negedge clk);
    cmd_valid = 1; cmd_cal = cal; cmd_int_clk = intc;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // Counts busy cycles from the current negedge; returns strobe consistency.
  task automatic count_busy(input logic exp_strobe, output int n, output bit strobe_ok);
    n = 0; strobe_ok = 1;
    while (busy && n < 100000) begin
      if (strobe !== exp_strobe) strobe_ok = 0;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sclk_pulse;
    sclk = 1;
    @(negedge clk);
    sclk = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit sok;
    logic [W-1:0] v, last_v;
    do_reset;
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(strobe == 1 && strobe_oe == 1 && dout == 0, "R1 strobe/oe/dout", {strobe, strobe_oe, dout}, 6);

    // R2 R3 R4 sweep of result patterns
    last_v = '0;
    for (int k = 0; k < 16; k++) begin
      v = (k == 0) ? '0 : (k == 1) ? '1 : (k < 8) ? W'(1 << (k * 2 - 3)) : W'((k * 12345) % (1 << W));
      sample_in = v;
      send(1'b0, 1'b1);
      count_busy(1'b0, n, sok);
      sample_in = ~v;
      chk(n == CONV, "R2 conversion length", n, CONV);
      chk(sok, "R2 strobe low while busy", sok, 1);
      chk(strobe == 1 && done == 1, "R3 strobe high and done", {strobe, done}, 3);
      chk(dout == v[W-1], "R3 MSB present", dout, v[W-1]);
      for (int b = W - 2; b >= 0; b--) begin
        sclk_pulse;
        chk(dout == v[b], "R4 readback bit", dout, v[b]);
      end
      chk(done == 0, "R4 done cleared after last bit", done, 0);
      sclk_pulse;
      chk(dout == v[0], "R4 extra edge no change", dout, v[0]);
      last_v = v;
    end

    // R4 cs_n high blocks shifting; R5 oe stays high in internal mode
    sample_in = 14'h2000;
    cs_n = 1;
    send(1'b0, 1'b1);
    chk(strobe_oe == 1 && strobe == 0, "R5 internal strobe driven with cs_n high", {strobe_oe, strobe}, 2);
    count_busy(1'b0, n, sok);
    sclk_pulse;
    chk(dout == 1 && done == 1, "R4 no shift with cs_n high", {dout, done}, 3);
    cs_n = 0;
    sclk_pulse;
    chk(dout == 0, "R4 shift after cs_n low", dout, 0);

    // R8 abort mid-conversion: dout unchanged, done cleared
    sample_in = '1;
    send(1'b0, 1'b1);
    repeat (8) @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(busy == 0 && done == 0, "R8 abort to idle", {busy, done}, 0);
    chk(dout == 0 && strobe == 1, "R8 dout kept, strobe idle", {dout, strobe}, 1);
    repeat (CONV) @(negedge clk);
    chk(done == 0 && dout == 0, "R8 no late completion", {done, dout}, 0);

    // R8 shutdown mid-calibration
    send(1'b1, 1'b1);
    repeat (5) @(negedge clk);
    shdn_n = 0;
    @(negedge clk);
    chk(busy == 0 && strobe == 1, "R8 shutdown stops calibration", {busy, strobe}, 1);
    // R11 command ignored during shutdown
    send(1'b0, 1'b1);
    chk(busy == 0, "R11 command ignored in shutdown", busy, 0);
    shdn_n = 1;
    @(negedge clk);

    // R9 restart during conversion
    send(1'b0, 1'b1);
    repeat (9) @(negedge clk);
    send(1'b0, 1'b1);
    count_busy(1'b0, n, sok);
    chk(n == CONV, "R9 restart gives full length", n, CONV);

    // R10 external conversion ignored
    send(1'b0, 1'b0);
    chk(busy == 0 && strobe == 1 && strobe_oe == 1, "R10 ext conversion ignored", {busy, strobe, strobe_oe}, 3);

    // R6 internal calibration
    send(1'b1, 1'b1);
    count_busy(1'b0, n, sok);
    chk(n == CAL, "R6 calibration length", n, CAL);
    chk(sok, "R6 strobe low during calibration", sok, 1);
    chk(strobe == 1 && done == 0, "R6 end state", {strobe, done}, 2);

    // R7 external calibration; R5 oe follows cs_n
    send(1'b1, 1'b0);
    count_busy(1'b1, n, sok);
    chk(n == CAL, "R7 ext calibration length", n, CAL);
    chk(sok, "R7 strobe high during calibration", sok, 1);
    chk(strobe == 0, "R7 strobe low at end", strobe, 0);
    cs_n = 1;
    @(negedge clk);
    chk(strobe_oe == 0, "R5 ext mode oe off with cs_n high", strobe_oe, 0);
    cs_n = 0;
    @(negedge clk);
    chk(strobe_oe == 1, "R5 ext mode oe on with cs_n low", strobe_oe, 1);

    // R12 reset restores internal mode
    do_reset;
    cs_n = 1;
    @(negedge clk);
    chk(strobe == 1 && strobe_oe == 1, "R12 internal mode after reset", {strobe, strobe_oe}, 3);
    cs_n = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule